// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator

This block is the command stage of a half-bridge controller. It takes one on/off request for the high-side switch and one for the low-side switch, and returns gated commands for the two output channels. Its guarantee is that the two channels are never on together. It also guarantees that a channel turns on only after a fixed, programmable number of clock cycles with the opposite channel off. This holds even when the incoming requests hand over with no gap at all.

The block resolves a request that asks for both switches by turning both channels off; it does not pick a winner. A pending turn-on is abandoned as soon as its request goes away. An active-low enable parks both channels off and restarts every pending wait. The inputs are expected to be already synchronous to `clk`. The fault gating applied further down the chain is not part of this block.

Top module: `halfbridge_deadtime`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released, both `hi_on` and `lo_on` are 0.
- R2: Once a channel is on, it stays on for as long as its own request alone is held with the block enabled. When its request drops, it goes off at the next rising edge.
- R3: If `hi_cmd` and `lo_cmd` are both 1 at a rising edge, both outputs are 0 after that edge, for as long as the overlap lasts.
- R4: `hi_on` and `lo_on` are never 1 in the same cycle.
- R5: Starting with both outputs off, a request held alone switches its output on at the (DEAD_CYC+1)-th rising edge at which it is sampled, and not earlier.
- R6: When the two requests swap in the same cycle, the active output goes off at the first edge. Both outputs then stay off for DEAD_CYC+1 cycles before the other output turns on. The gap is the same in the high-to-low and low-to-high directions.
- R7: If a request drops before its output has turned on, the wait is cancelled. A later request must again wait the full count of R5.
- R8: While `en_n` is 1, both outputs are 0 from the next edge on and all waits are reset. After `en_n` returns to 0, a held request follows R5 from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Active-low enable; 1 forces both channels off |
| hi_cmd | input | 1 | High-side on request |
| lo_cmd | input | 1 | Low-side on request |
| hi_on | output | 1 | Gated high-side on command |
| lo_on | output | 1 | Gated low-side on command |

## Verification
The bench drives zero-gap handovers in both directions and checks that the both-off gap is the same length each way. A design that skipped the gap, or counted it from the wrong event, would let the other output rise too early or would make the two directions differ. Overlapping requests are held for a long time: a design that gave one side priority would turn an output on during the overlap.

A request is dropped partway through its wait and then raised again, which exposes a design that keeps the partial count and turns on too soon. Disabling the block while the low side is on, then re-enabling it, shows whether the wait counters are cleared or left stale. A reset in the middle of operation confirms that the outputs clear and the full wait is taken again.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

    // Index of each leg inside the internal leg vectors
    localparam int LEG_HI = 0;
    localparam int LEG_LO = 1;
    localparam int N_LEGS = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_pair_t;

    // A leg is requested only when it alone is asked for and the block is enabled.
    function automatic leg_pair_t resolve_req(leg_pair_t cmd, logic enable);
        leg_pair_t r;
        r.hi = enable & cmd.hi & ~cmd.lo;
        r.lo = enable & cmd.lo & ~cmd.hi;
        return r;
    endfunction

endpackage

// File: rtl/hb_dt_request.sv
module hb_dt_request
    import hb_dt_pkg::*;
(
    input  logic      en_n,
    input  leg_pair_t cmd,
    output leg_pair_t req
);

    // R3: overlapping requests resolve to no request; R8: disable masks both
    always_comb begin
        req = resolve_req(cmd, ~en_n);
    end

endmodule

// File: rtl/hb_dt_leg.sv
module hb_dt_leg #(
    parameter int DEAD_CYC = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic opp_on,
    output logic on
);

    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEAD_CYC);

    logic [CW-1:0] wait_cnt;
    logic          wait_done;

    assign wait_done = (wait_cnt == CNT_FULL) && !opp_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            on       <= 1'b0;
        end else begin
            // R7: a dropped request abandons its wait
            if (!req) begin
                wait_cnt <= '0;
            end else if (!opp_on && wait_cnt != CNT_FULL) begin
                wait_cnt <= wait_cnt + CW'(1);
            end
            // R2/R5: hold while requested, turn on only after the full wait
            on <= req & (on | wait_done);
        end
    end

endmodule

// File: rtl/halfbridge_deadtime.sv
module halfbridge_deadtime
    import hb_dt_pkg::*;
#(
    parameter int DEAD_CYC = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    output logic hi_on,
    output logic lo_on
);

    leg_pair_t          cmd_pair;
    leg_pair_t          req_pair;
    logic [N_LEGS-1:0]  req_v;
    logic [N_LEGS-1:0]  on_v;

    assign cmd_pair.hi = hi_cmd;
    assign cmd_pair.lo = lo_cmd;

    hb_dt_request u_req (
        .en_n (en_n),
        .cmd  (cmd_pair),
        .req  (req_pair)
    );

    assign req_v[LEG_HI] = req_pair.hi;
    assign req_v[LEG_LO] = req_pair.lo;

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        localparam int OPP = N_LEGS - 1 - g;
        hb_dt_leg #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk    (clk),
            .rst    (rst),
            .req    (req_v[g]),
            .opp_on (on_v[OPP]),
            .on     (on_v[g])
        );
    end

    assign hi_on = on_v[LEG_HI];
    assign lo_on = on_v[LEG_LO];

endmodule

// File: rtl/halfbridge_deadtime_chk.sv
module halfbridge_deadtime_chk #(
    parameter int DEAD_CYC = 33
) (
    input logic clk,
    input logic rst,
    input logic en_n,
    input logic hi_cmd,
    input logic lo_cmd,
    input logic hi_on,
    input logic lo_on
);

    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

    // Cycles each output has been observed off, saturating
    logic [CW-1:0] hi_off_cnt;
    logic [CW-1:0] lo_off_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_off_cnt <= '0;
            lo_off_cnt <= '0;
        end else begin
            if (hi_on) hi_off_cnt <= '0;
            else if (hi_off_cnt != SAT) hi_off_cnt <= hi_off_cnt + CW'(1);
            if (lo_on) lo_off_cnt <= '0;
            else if (lo_off_cnt != SAT) lo_off_cnt <= lo_off_cnt + CW'(1);
        end
    end

    // R4
    never_both_on_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_on && lo_on));

    // R3
    overlap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_cmd && lo_cmd) |=> (!hi_on && !lo_on));

    // R8
    disable_off_chk: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (!hi_on && !lo_on));

    // R2
    hi_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !hi_cmd |=> !hi_on);

    // R2
    lo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !lo_cmd |=> !lo_on);

    // R2
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_on && hi_cmd && !lo_cmd && !en_n) |=> hi_on);

    // R6
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_on) |-> (lo_off_cnt == SAT));

    // R6
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_on) |-> (hi_off_cnt == SAT));

endmodule

bind halfbridge_deadtime halfbridge_deadtime_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (.*);

// File: tb/test_halfbridge_deadtime.sv
module test_halfbridge_deadtime;

    localparam int CLK_PERIOD = 10;
    localparam int D = 5;

    typedef struct packed {
        logic       en_n;
        logic       hi;
        logic       lo;
        logic [7:0] cyc;
        logic       eh;
        logic       el;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TAB [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'(D),   1'b0, 1'b0, 4'd5}, // R5 not yet on
        '{1'b0, 1'b1, 1'b0, 8'd1,    1'b1, 1'b0, 4'd5}, // R5 on at edge D+1
        '{1'b0, 1'b1, 1'b0, 8'd10,   1'b1, 1'b0, 4'd2}, // R2 held
        '{1'b0, 1'b0, 1'b1, 8'd1,    1'b0, 1'b0, 4'd6}, // R6 hi off at once
        '{1'b0, 1'b0, 1'b1, 8'(D),   1'b0, 1'b0, 4'd6}, // R6 gap still open
        '{1'b0, 1'b0, 1'b1, 8'd1,    1'b0, 1'b1, 4'd6}, // R6 lo on after gap
        '{1'b0, 1'b1, 1'b1, 8'd1,    1'b0, 1'b0, 4'd3}, // R3 overlap
        '{1'b0, 1'b1, 1'b1, 8'd20,   1'b0, 1'b0, 4'd3}, // R3 long overlap
        '{1'b0, 1'b0, 1'b1, 8'(D),   1'b0, 1'b0, 4'd5}, // R5 after overlap
        '{1'b0, 1'b0, 1'b1, 8'd1,    1'b0, 1'b1, 4'd5}, // R5
        '{1'b0, 1'b1, 1'b0, 8'(D+1), 1'b0, 1'b0, 4'd6}, // R6 lo-to-hi gap
        '{1'b0, 1'b1, 1'b0, 8'd1,    1'b1, 1'b0, 4'd6}, // R6
        '{1'b0, 1'b0, 1'b0, 8'd1,    1'b0, 1'b0, 4'd2}, // R2 drop
        '{1'b0, 1'b0, 1'b1, 8'd3,    1'b0, 1'b0, 4'd7}, // R7 partial wait
        '{1'b0, 1'b0, 1'b0, 8'd1,    1'b0, 1'b0, 4'd7}, // R7 cancel
        '{1'b0, 1'b0, 1'b1, 8'(D),   1'b0, 1'b0, 4'd7}, // R7 full wait again
        '{1'b0, 1'b0, 1'b1, 8'd1,    1'b0, 1'b1, 4'd7}, // R7
        '{1'b1, 1'b0, 1'b1, 8'd1,    1'b0, 1'b0, 4'd8}, // R8 disable
        '{1'b1, 1'b0, 1'b1, 8'd20,   1'b0, 1'b0, 4'd8}, // R8
        '{1'b0, 1'b0, 1'b1, 8'(D),   1'b0, 1'b0, 4'd8}, // R8 wait restarted
        '{1'b0, 1'b0, 1'b1, 8'd1,    1'b0, 1'b1, 4'd8}  // R8
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd = 1'b0;
    logic hi_on;
    logic lo_on;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfbridge_deadtime #(.DEAD_CYC(D)) i_halfbridge_deadtime (
        .clk    (clk),
        .rst    (rst),
        .en_n   (en_n),
        .hi_cmd (hi_cmd),
        .lo_cmd (lo_cmd),
        .hi_on  (hi_on),
        .lo_on  (lo_on)
    );

    task automatic check(input logic eh, input logic el, input int rq);
        n_chk++;
        if (hi_on !== eh || lo_on !== el) begin
            n_fail++;
            $display("FAIL R%0d: got hi=%b lo=%b expected hi=%b lo=%b",
                     rq, hi_on, lo_on, eh, el);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        run(3);
        check(1'b0, 1'b0, 1);
        rst = 1'b0;
        run(1);
        check(1'b0, 1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            en_n   = TAB[i].en_n;
            hi_cmd = TAB[i].hi;
            lo_cmd = TAB[i].lo;
            run(int'(TAB[i].cyc));
            check(TAB[i].eh, TAB[i].el, int'(TAB[i].req));
        end

        // R1: reset mid-operation with lo on, then the full wait again
        rst = 1'b1;
        run(1);
        check(1'b0, 1'b0, 1);
        rst = 1'b0;
        run(D);
        check(1'b0, 1'b0, 5);
        run(1);
        check(1'b0, 1'b1, 5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule